// File: doc/BRIEF.md
# NAND Flash Bus Strobe Sequencer

This block drives the control strobes of a NAND flash bus for one access at a time. A single access is either a read cycle, which pulses the read-enable strobe, or a write cycle, which pulses the write-enable strobe and then waits for the flash to report ready. The duration of every phase comes from a packed 32-bit timing word. The word is sampled when the access starts, so software may rewrite it while an access is running without disturbing that access.

An access opens with a bus turnaround gap when its direction differs from the previous access. A read that finds chip-enable inactive first waits a chip-enable-to-read setup time. The strobe then goes low and high for its programmed widths. A write then waits a fixed busy-sample delay, during which the ready/busy line is ignored, and after that it waits for as long as the line reads busy. A one-clock done pulse closes the access. Chip-enable stays asserted between accesses until the controller drops it explicitly.

Top module: `nand_strobe_gen`

## Requirements
- R1: While reset is held and on the first cycle after it, `ce_n`, `re_n` and `we_n` are 1 and `rd_capture` and `acc_done` are 0.
- R2: In a write, `we_n` is low for WL+1 cycles and then high for WH+1 cycles. WL is `tword[3:0]`, WH is `tword[7:4]`, and a field value of 0 gives one cycle.
- R3: In a read, `re_n` is low for RL+1 cycles and then high for RH+1 cycles. RL is `tword[11:8]` and RH is `tword[15:12]`.
- R4: `rd_capture` is 1 only in the last cycle in which `re_n` is low, so that `re_n` rises at the clock edge that captures the data. It is never 1 in a write.
- R5: When an access has the opposite direction to the previous one since reset, it starts with TA+1 cycles in which all strobes are high, with TA = `tword[18:16]`. Accesses in the same direction, and the first access after reset, have no gap.
- R6: A read accepted while `ce_n` is high waits CS+1 cycles with `ce_n` low and both strobes high before `re_n` falls, with CS = `tword[25:24]`. Writes, and reads accepted while `ce_n` is already low, skip this wait.
- R7: After the high phase of a write comes a wait of BD+1 cycles, with BD = `tword[23:19]`, in which `flash_rdy` is ignored. After that, the access waits for as long as `flash_rdy` is 0.
- R8: `acc_done` is 1 for exactly one cycle. It follows the high phase of a read, or the first cycle of a write's ready wait in which `flash_rdy` is 1. The next access can be accepted in the cycle after the done pulse.
- R9: `ce_n` goes low in the first cycle of an access and stays low until `ce_drop` is pulsed while the block is idle. `re_n` and `we_n` are low only while `ce_n` is low.
- R10: `acc_start` has no effect while an access is in progress. `acc_rd` and `tword` are used only in the cycle in which an access is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_start | input | 1 | Start-access pulse, accepted only when idle |
| acc_rd | input | 1 | Access direction: 1 read, 0 write |
| ce_drop | input | 1 | Deasserts chip-enable when idle |
| flash_rdy | input | 1 | Synchronised ready/busy line, 1 = ready |
| tword | input | 32 | Packed phase-count word |
| ce_n | output | 1 | Chip-enable, active low |
| re_n | output | 1 | Read-enable strobe, active low |
| we_n | output | 1 | Write-enable strobe, active low |
| rd_capture | output | 1 | Read data capture strobe |
| acc_done | output | 1 | One-cycle access-complete pulse |

## Verification
The bench builds the block with its default 5-bit phase counter, which covers the widest field in full. The all-zero timing word and the all-ones timing word can therefore both be applied: the first gives one-cycle phases everywhere, and the second gives the longest turnaround, setup, strobe and busy-delay phases. Random timing words, random directions and random busy-extension lengths, along with occasional chip-enable drops, exercise every combination of turnaround and setup insertion. One access has a stray start pulse in the middle, and the word is scrambled after every start, to show that only the sampled values matter.

// File: rtl/nand_strobe_pkg.sv
package nand_strobe_pkg;

    localparam int TWORD_W = 32;
    localparam int CNT_W   = 5;

    // Field positions in the timing word (decoded by software-visible layout)
    localparam int WL_LSB = 0;
    localparam int WH_LSB = 4;
    localparam int RL_LSB = 8;
    localparam int RH_LSB = 12;
    localparam int TA_LSB = 16;
    localparam int BD_LSB = 19;
    localparam int CS_LSB = 24;

    typedef struct packed {
        logic [1:0] ce_setup;
        logic [4:0] busy_dly;
        logic [2:0] turn;
        logic [3:0] rd_hi;
        logic [3:0] rd_lo;
        logic [3:0] wr_hi;
        logic [3:0] wr_lo;
    } strobe_timing_t;

    typedef enum logic [2:0] {
        PH_IDLE, PH_TURN, PH_SETUP, PH_LOW, PH_HIGH, PH_BDLY, PH_WAIT, PH_DONE
    } phase_t;

    function automatic strobe_timing_t unpack_timing(input logic [TWORD_W-1:0] w);
        strobe_timing_t t;
        t.wr_lo    = w[WL_LSB +: 4];
        t.wr_hi    = w[WH_LSB +: 4];
        t.rd_lo    = w[RL_LSB +: 4];
        t.rd_hi    = w[RH_LSB +: 4];
        t.turn     = w[TA_LSB +: 3];
        t.busy_dly = w[BD_LSB +: 5];
        t.ce_setup = w[CS_LSB +: 2];
        return t;
    endfunction

    function automatic logic [CNT_W-1:0] phase_count(input phase_t ph, input logic rd,
                                                     input strobe_timing_t t);
        logic [CNT_W-1:0] v;
        case (ph)
            PH_TURN:  v = CNT_W'(t.turn);
            PH_SETUP: v = CNT_W'(t.ce_setup);
            PH_LOW:   v = rd ? CNT_W'(t.rd_lo) : CNT_W'(t.wr_lo);
            PH_HIGH:  v = rd ? CNT_W'(t.rd_hi) : CNT_W'(t.wr_hi);
            PH_BDLY:  v = CNT_W'(t.busy_dly);
            default:  v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/nand_timing_latch.sv
module nand_timing_latch
    import nand_strobe_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [TWORD_W-1:0] word,
    output strobe_timing_t     live,
    output strobe_timing_t     held
);
    assign live = unpack_timing(word);

    always_ff @(posedge clk) begin
        if (rst)       held <= '0;
        else if (load) held <= live;
    end
endmodule

// File: rtl/nand_phase_counter.sv
module nand_phase_counter #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign last = (cnt == '0);
endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
    import nand_strobe_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_start,
    input  logic             acc_rd,
    input  logic             ce_drop,
    input  logic             flash_rdy,
    input  strobe_timing_t   live_tim,
    input  strobe_timing_t   held_tim,
    input  logic             cnt_last,
    output logic             accept,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_val,
    output logic             ce_n,
    output logic             re_n,
    output logic             we_n,
    output logic             rd_capture,
    output logic             acc_done
);
    phase_t         state, nxt;
    logic           cur_rd, setup_req, ce_held, has_prev, last_rd;
    strobe_timing_t tim;
    logic           rd_eff, setup_eff, turn_eff;

    assign accept    = (state == PH_IDLE) && acc_start;
    assign tim       = (state == PH_IDLE) ? live_tim : held_tim;
    assign rd_eff    = (state == PH_IDLE) ? acc_rd : cur_rd;
    assign setup_eff = (state == PH_IDLE) ? (acc_rd && !ce_held) : setup_req;
    assign turn_eff  = has_prev && (last_rd != acc_rd);

    always_comb begin
        nxt = state;
        case (state)
            PH_IDLE:  if (acc_start)
                          nxt = turn_eff ? PH_TURN : (setup_eff ? PH_SETUP : PH_LOW);
            PH_TURN:  if (cnt_last) nxt = setup_eff ? PH_SETUP : PH_LOW;
            PH_SETUP: if (cnt_last) nxt = PH_LOW;
            PH_LOW:   if (cnt_last) nxt = PH_HIGH;
            PH_HIGH:  if (cnt_last) nxt = rd_eff ? PH_DONE : PH_BDLY;
            PH_BDLY:  if (cnt_last) nxt = PH_WAIT;
            PH_WAIT:  if (flash_rdy) nxt = PH_DONE;
            default:  nxt = PH_IDLE;
        endcase
    end

    assign cnt_load = (nxt != state);
    assign cnt_val  = phase_count(nxt, rd_eff, tim);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= PH_IDLE;
            cur_rd    <= 1'b0;
            setup_req <= 1'b0;
            ce_held   <= 1'b0;
            has_prev  <= 1'b0;
            last_rd   <= 1'b0;
        end else begin
            state <= nxt;
            if (accept) begin
                cur_rd    <= acc_rd;
                setup_req <= acc_rd && !ce_held;
                ce_held   <= 1'b1;
                has_prev  <= 1'b1;
                last_rd   <= acc_rd;
            end else if (state == PH_IDLE && ce_drop) begin
                ce_held <= 1'b0;
            end
        end
    end

    assign ce_n       = !ce_held;
    assign re_n       = !(state == PH_LOW && cur_rd);
    assign we_n       = !(state == PH_LOW && !cur_rd);
    assign rd_capture = (state == PH_LOW) && cur_rd && cnt_last;
    assign acc_done   = (state == PH_DONE);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        acc_done |=> !acc_done); // R8
    AST_STROBE_UNDER_CE: assert property (@(posedge clk) disable iff (rst)
        (!re_n || !we_n) |-> !ce_n); // R9
    AST_CAPTURE_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        rd_capture |=> $rose(re_n)); // R4
    AST_WRITE_DONE_READY: assert property (@(posedge clk) disable iff (rst)
        (acc_done && !cur_rd) |-> $past(flash_rdy)); // R7
    AST_CE_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(ce_n) |-> $past(ce_drop)); // R9
endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
    import nand_strobe_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               acc_start,
    input  logic               acc_rd,
    input  logic               ce_drop,
    input  logic               flash_rdy,
    input  logic [TWORD_W-1:0] tword,
    output logic               ce_n,
    output logic               re_n,
    output logic               we_n,
    output logic               rd_capture,
    output logic               acc_done
);
    strobe_timing_t   live_tim, held_tim;
    logic             accept, cnt_load, cnt_last;
    logic [CNT_W-1:0] cnt_val;

    nand_timing_latch u_latch (
        .clk(clk), .rst(rst), .load(accept), .word(tword),
        .live(live_tim), .held(held_tim)
    );

    nand_phase_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val), .last(cnt_last)
    );

    nand_strobe_seq u_seq (
        .clk(clk), .rst(rst), .acc_start(acc_start), .acc_rd(acc_rd),
        .ce_drop(ce_drop), .flash_rdy(flash_rdy),
        .live_tim(live_tim), .held_tim(held_tim), .cnt_last(cnt_last),
        .accept(accept), .cnt_load(cnt_load), .cnt_val(cnt_val),
        .ce_n(ce_n), .re_n(re_n), .we_n(we_n),
        .rd_capture(rd_capture), .acc_done(acc_done)
    );
endmodule

// File: tb/nand_strobe_gen_test.sv
module nand_strobe_gen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_start = 1'b0, acc_rd = 1'b0, ce_drop = 1'b0, flash_rdy = 1'b1;
    logic [31:0] tword = '0;
    logic        ce_n, re_n, we_n, rd_capture, acc_done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    bit m_ce_held  = 0;
    bit m_has_prev = 0;
    bit m_last_rd  = 0;

    always #2.5 clk = ~clk;

    nand_strobe_gen uut (
        .clk(clk), .rst(rst), .acc_start(acc_start), .acc_rd(acc_rd),
        .ce_drop(ce_drop), .flash_rdy(flash_rdy), .tword(tword),
        .ce_n(ce_n), .re_n(re_n), .we_n(we_n),
        .rd_capture(rd_capture), .acc_done(acc_done)
    );

    function automatic logic [4:0] outs();
        return {ce_n, re_n, we_n, rd_capture, acc_done};
    endfunction

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {ce_n,re_n,we_n,cap,done} actual %b expected %b at cycle %0d",
                     req, act, exp, cycles);
        end
    endtask

    // kinds: 0 turn, 1 setup, 2 low, 3 high, 4 busy delay, 5 ready wait
    task automatic run_access(input bit rd, input logic [31:0] w, input int extra,
                              input bit poke, input string tag);
        int kind[6];
        int len[6];
        int n = 0;
        int g = 0;
        logic [4:0] e;
        string req;
        if (m_has_prev && (m_last_rd != rd)) begin kind[n] = 0; len[n] = int'(w[18:16]) + 1; n++; end
        if (rd && !m_ce_held)               begin kind[n] = 1; len[n] = int'(w[25:24]) + 1; n++; end
        kind[n] = 2; len[n] = (rd ? int'(w[11:8])  : int'(w[3:0])) + 1; n++;
        kind[n] = 3; len[n] = (rd ? int'(w[15:12]) : int'(w[7:4])) + 1; n++;
        if (!rd) begin
            kind[n] = 4; len[n] = int'(w[23:19]) + 1; n++;
            kind[n] = 5; len[n] = extra + 1; n++;
        end
        acc_start = 1'b1; acc_rd = rd; tword = w;
        @(negedge clk);
        acc_start = 1'b0; tword = $urandom; acc_rd = $urandom;  // R10: ignored after accept
        for (int s = 0; s < n; s++) begin
            for (int i = 0; i < len[s]; i++) begin
                flash_rdy = (kind[s] == 4) ? 1'b0 : (kind[s] == 5) ? (i >= extra) : 1'b1;
                e = 5'b01100;
                if (kind[s] == 2) begin
                    if (rd) e = {1'b0, 1'b0, 1'b1, (i == len[s] - 1), 1'b0};
                    else    e = 5'b01000;
                end
                case (kind[s])
                    0: req = "R5";
                    1: req = "R6";
                    2, 3: req = rd ? "R3/R4" : "R2";
                    default: req = "R7";
                endcase
                if (tag != "") req = tag;
                chk(req, outs(), e);
                acc_start = (poke && g == 1);
                g++;
                @(negedge clk);
            end
        end
        acc_start = 1'b0; flash_rdy = 1'b1;
        chk(tag != "" ? tag : "R8", outs(), 5'b01101);
        @(negedge clk);
        chk("R8 idle after done", outs(), 5'b01100);
        m_ce_held = 1; m_has_prev = 1; m_last_rd = rd;
    endtask

    task automatic drop_ce();
        ce_drop = 1'b1;
        @(negedge clk);
        ce_drop = 1'b0;
        chk("R9 ce dropped", outs(), 5'b11100);
        m_ce_held = 0;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 in reset", outs(), 5'b11100);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", outs(), 5'b11100);

        // Directed corners
        run_access(1'b0, 32'h0, 0, 1'b0, "");           // R2 zero fields, no turn first
        run_access(1'b0, 32'h0, 2, 1'b0, "");           // R2 same direction, no gap
        run_access(1'b1, 32'h0, 0, 1'b0, "");           // R5 turn, R6 skipped (ce held)
        drop_ce();
        run_access(1'b1, 32'h03FF_FFFF, 0, 1'b0, "");   // R6 setup max, R3 max
        run_access(1'b0, 32'h03FF_FFFF, 3, 1'b0, "");   // R5 max turn, R7 max delay
        run_access(1'b0, 32'h0123_4567, 1, 1'b1, "R10 stray start");
        drop_ce();
        run_access(1'b0, 32'h0300_0021, 0, 1'b0, "");   // R6 not applied to writes

        // Random
        for (int k = 0; k < 60; k++) begin
            if ($urandom_range(3) == 0) drop_ce();
            run_access(1'($urandom_range(1)), $urandom, int'($urandom_range(4)),
                       1'($urandom_range(1)), "");
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule